// File: doc/BRIEF.md
# Ranked Ready-Instruction Issue Picker

This block holds up to `N` dispatched instruction entries in a small window and picks one of them to issue each cycle. Each entry stores a sequence index and a count of known dependent users. An entry starts out waiting or ready, depending on whether its operands are available when it is dispatched. Waiting entries are promoted to ready when their operand-ready line goes high. Among the ready entries, the picker issues the one with the lowest rank, where rank is the sequence index minus the user count, taken as a signed value. This gives priority to instructions that unblock many others, and otherwise to older ones.

An issued entry stays in its slot in an executing state until a write-back pulse carrying its tag frees the slot. Before an instruction is accepted, the dispatch side reads a status code. The code reports whether the slot pool is exhausted, whether the load or store queues are full (these are supplied as flags), or whether the dispatch group has to stall. The tag returned on dispatch is the slot index, and issue and write-back use the same tag.

Top module: `issue_picker`

## Requirements
- R1: After reset all slots are free: `iss_valid` is 0, `disp_tag` is 0, and `disp_status` is 0 when no stall input is active.
- R2: A dispatch is accepted when `disp_valid` is 1 and `disp_status` is 0. An entry dispatched with `disp_ops_ready`=1 becomes eligible for issue in the following cycle.
- R3: An entry dispatched with `disp_ops_ready`=0 waits until `opnd_rdy[tag]` is 1 in some cycle, and becomes eligible for issue in the cycle after that one.
- R4: Among the eligible entries, the issued one has the lowest rank. Rank is sequence index minus user count, computed as a signed number, so a negative rank beats any positive rank.
- R5: When ranks are equal, the entry with the smaller sequence index (compared unsigned) wins. If the sequence indices are also equal, the lower slot number wins.
- R6: `iss_valid` is 0 when `res_avail` is 0 or when no entry is eligible. In that cycle no entry changes state because of issue.
- R7: At most one entry issues per cycle. An issued entry executes until `wb_valid` is seen with its tag, and then its slot is free in the next cycle. A write-back to a slot that is not executing has no effect.
- R8: `disp_status` codes and their priority are: 1 when `disp_is_load` and `lq_full` are both set; otherwise 2 when `disp_is_store` and `sq_full` are both set; otherwise 3 when no slot is free; otherwise 4 when `grp_stall` is set; otherwise 0.
- R9: When all `N` slots are occupied, `disp_status` is 3 and a dispatch is not accepted.
- R10: `disp_tag` is the lowest-numbered free slot, or 0 when no slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | SEQ_W | Sequence index of the dispatched instruction |
| disp_users | input | USR_W | Known dependent user count |
| disp_ops_ready | input | 1 | Operands already available at dispatch |
| disp_is_load | input | 1 | Instruction needs a load queue entry |
| disp_is_store | input | 1 | Instruction needs a store queue entry |
| lq_full | input | 1 | Load queue full flag |
| sq_full | input | 1 | Store queue full flag |
| grp_stall | input | 1 | Dispatch group stall request |
| disp_status | output | 3 | Dispatch stall code (R8) |
| disp_tag | output | log2(N) | Slot the dispatch would occupy |
| opnd_rdy | input | N | Per-slot operand-available lines |
| res_avail | input | 1 | Execution resource available this cycle |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_tag | output | log2(N) | Slot of the issuing entry |
| wb_valid | input | 1 | Write-back event |
| wb_tag | input | log2(N) | Slot finishing write-back |

## Verification
The hardest case to reach is a selection where the signed rank decides the outcome. This happens when a young entry with many users has a negative rank and must beat an older entry that has a small positive rank. It also happens in an exact rank tie that must fall back to the sequence index. Directed steps hold `res_avail` low while such pairs are dispatched, so that both entries are eligible together before release. The random phase draws small sequence indices against user counts of up to 15, so negative ranks and ties occur often, and every issue is compared with a bench-side ranking model.

// File: rtl/issue_picker.sv
module issue_picker #(
  parameter int N     = 8,
  parameter int SEQ_W = 8,
  parameter int USR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_valid,
  input  logic [SEQ_W-1:0]   disp_seq,
  input  logic [USR_W-1:0]   disp_users,
  input  logic               disp_ops_ready,
  input  logic               disp_is_load,
  input  logic               disp_is_store,
  input  logic               lq_full,
  input  logic               sq_full,
  input  logic               grp_stall,
  output logic [2:0]         disp_status,
  output logic [$clog2(N)-1:0] disp_tag,
  input  logic [N-1:0]       opnd_rdy,
  input  logic               res_avail,
  output logic               iss_valid,
  output logic [$clog2(N)-1:0] iss_tag,
  input  logic               wb_valid,
  input  logic [$clog2(N)-1:0] wb_tag
);
  localparam int TAG_W = $clog2(N);
  localparam int RW    = ((SEQ_W > USR_W) ? SEQ_W : USR_W) + 2;
  localparam logic [1:0] S_FREE = 2'd0, S_WAIT = 2'd1, S_RDY = 2'd2, S_EXEC = 2'd3;

  logic [1:0]           st    [N];
  logic [SEQ_W-1:0]     seq_q [N];
  logic [USR_W-1:0]     usr_q [N];
  logic signed [RW-1:0] rank  [N];

  logic                 any_free, best_v, disp_acc;
  logic [TAG_W-1:0]     free_tag, best_tag;
  logic signed [RW-1:0] best_rank;
  logic [SEQ_W-1:0]     best_seq;

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign rank[g] = $signed({{(RW-SEQ_W){1'b0}}, seq_q[g]}) -
                     $signed({{(RW-USR_W){1'b0}}, usr_q[g]});
  end

  always_comb begin
    any_free = 1'b0;
    free_tag = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (st[i] == S_FREE) begin
        any_free = 1'b1;
        free_tag = TAG_W'(i);
      end
    end
  end

  always_comb begin
    if (disp_is_load && lq_full)       disp_status = 3'd1;
    else if (disp_is_store && sq_full) disp_status = 3'd2;
    else if (!any_free)                disp_status = 3'd3;
    else if (grp_stall)                disp_status = 3'd4;
    else                               disp_status = 3'd0;
  end

  assign disp_tag = free_tag;
  assign disp_acc = disp_valid && (disp_status == 3'd0);

  always_comb begin
    best_v    = 1'b0;
    best_tag  = '0;
    best_rank = '0;
    best_seq  = '0;
    for (int i = 0; i < N; i++) begin
      if (st[i] == S_RDY) begin
        if (!best_v || rank[i] < best_rank ||
            (rank[i] == best_rank && seq_q[i] < best_seq)) begin
          best_v    = 1'b1;
          best_tag  = TAG_W'(i);
          best_rank = rank[i];
          best_seq  = seq_q[i];
        end
      end
    end
  end

  assign iss_valid = res_avail && best_v;
  assign iss_tag   = best_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        st[i]    <= S_FREE;
        seq_q[i] <= '0;
        usr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        case (st[i])
          S_FREE:
            if (disp_acc && free_tag == TAG_W'(i)) begin
              st[i]    <= disp_ops_ready ? S_RDY : S_WAIT;
              seq_q[i] <= disp_seq;
              usr_q[i] <= disp_users;
            end
          S_WAIT: if (opnd_rdy[i]) st[i] <= S_RDY;
          S_RDY:  if (iss_valid && iss_tag == TAG_W'(i)) st[i] <= S_EXEC;
          default: if (wb_valid && wb_tag == TAG_W'(i)) st[i] <= S_FREE;
        endcase
      end
    end
  end
endmodule

// File: rtl/issue_picker_chk.sv
module issue_picker_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 disp_is_load,
  input logic                 disp_is_store,
  input logic                 lq_full,
  input logic                 sq_full,
  input logic [2:0]           disp_status,
  input logic                 res_avail,
  input logic                 iss_valid,
  input logic [$clog2(N)-1:0] iss_tag
);
  AST_NO_ISSUE_WITHOUT_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !res_avail |-> !iss_valid); // R6
  AST_NO_REPEAT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !(iss_valid && iss_tag == $past(iss_tag))); // R7
  AST_LQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_is_load && lq_full) |-> disp_status == 3'd1); // R8
  AST_SQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_is_store && sq_full && !(disp_is_load && lq_full)) |-> disp_status == 3'd2); // R8
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    disp_status <= 3'd4); // R8
endmodule

bind issue_picker issue_picker_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_is_load(disp_is_load), .disp_is_store(disp_is_store),
  .lq_full(lq_full), .sq_full(sq_full), .disp_status(disp_status),
  .res_avail(res_avail), .iss_valid(iss_valid), .iss_tag(iss_tag)
);

// File: tb/issue_picker_bench.sv
module issue_picker_bench;
  localparam int N = 8, SEQ_W = 8, USR_W = 4, TAG_W = 3;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_ops_ready = 0, disp_is_load = 0, disp_is_store = 0;
  logic lq_full = 0, sq_full = 0, grp_stall = 0, res_avail = 0, wb_valid = 0;
  logic [SEQ_W-1:0] disp_seq = 0;
  logic [USR_W-1:0] disp_users = 0;
  logic [N-1:0] opnd_rdy = 0;
  logic [TAG_W-1:0] wb_tag = 0;
  logic [2:0] disp_status;
  logic [TAG_W-1:0] disp_tag, iss_tag;
  logic iss_valid;

  int checks = 0, failures = 0;
  int m_st [N];
  int m_seq [N];
  int m_usr [N];

  always #2.5 clk = ~clk;

  issue_picker #(.N(N), .SEQ_W(SEQ_W), .USR_W(USR_W)) u_issue_picker (.*);

  function automatic int f_free();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int f_status();
    if (disp_is_load && lq_full) return 1;
    if (disp_is_store && sq_full) return 2;
    if (f_free() < 0) return 3;
    if (grp_stall) return 4;
    return 0;
  endfunction

  function automatic int f_pick();
    int b = -1;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] == 2) begin
        if (b < 0) b = i;
        else if ((m_seq[i] - m_usr[i]) < (m_seq[b] - m_usr[b]) ||
                 ((m_seq[i] - m_usr[i]) == (m_seq[b] - m_usr[b]) && m_seq[i] < m_seq[b]))
          b = i;
      end
    end
    return b;
  endfunction

  task automatic chk(input string rq, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic step(input string rq);
    int p, fr, stv, et;
    #1;
    p = f_pick(); fr = f_free(); stv = f_status();
    et = (res_avail && p >= 0) ? 1 : 0;
    chk(rq, int'(iss_valid), et, "iss_valid");
    if (et == 1) chk(rq, int'(iss_tag), p, "iss_tag");
    chk(rq, int'(disp_status), stv, "disp_status");
    chk(rq, int'(disp_tag), (fr < 0) ? 0 : fr, "disp_tag");
    for (int i = 0; i < N; i++) begin
      case (m_st[i])
        0: if (disp_valid && stv == 0 && fr == i) begin
             m_st[i] = disp_ops_ready ? 2 : 1;
             m_seq[i] = int'(disp_seq); m_usr[i] = int'(disp_users);
           end
        1: if (opnd_rdy[i]) m_st[i] = 2;
        2: if (et == 1 && p == i) m_st[i] = 3;
        default: if (wb_valid && int'(wb_tag) == i) m_st[i] = 0;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    disp_valid = 0; disp_ops_ready = 0; disp_is_load = 0; disp_is_store = 0;
    lq_full = 0; sq_full = 0; grp_stall = 0; wb_valid = 0; opnd_rdy = '0;
  endtask

  task automatic disp(input int s, input int u, input bit rdy, input string rq);
    quiet();
    disp_valid = 1; disp_seq = SEQ_W'(s); disp_users = USR_W'(u); disp_ops_ready = rdy;
    step(rq);
  endtask

  task automatic drain(input string rq);
    for (int k = 0; k < 40; k++) begin
      quiet(); res_avail = 1;
      for (int i = 0; i < N; i++) if (m_st[i] == 3) begin
        wb_valid = 1; wb_tag = TAG_W'(i);
      end
      opnd_rdy = '1;
      step(rq);
    end
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_seq[i] = 0; m_usr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1");
    // negative rank against positive rank, R4
    res_avail = 0;
    disp(2, 5, 1, "R2");
    disp(1, 0, 1, "R10");
    quiet(); step("R6");
    res_avail = 1; step("R4");
    step("R4");
    drain("R7");
    // tie on rank, R5
    res_avail = 0;
    disp(5, 2, 1, "R2");
    disp(4, 1, 1, "R2");
    disp(4, 1, 1, "R5");
    quiet(); res_avail = 1; step("R5");
    step("R5"); step("R5");
    // write-back to a non-executing slot is ignored, R7
    quiet(); wb_valid = 1; wb_tag = 3'd6; step("R7");
    drain("R7");
    // waiting entry, R3
    res_avail = 1;
    disp(0, 0, 0, "R3");
    quiet(); step("R3"); step("R3");
    opnd_rdy[0] = 1; step("R3");
    quiet(); step("R3");
    drain("R3");
    // fill the pool, R9 and status priority R8
    res_avail = 0;
    for (int k = 0; k < N; k++) disp(10 + k, k, k[0], "R9");
    disp(50, 0, 1, "R9");
    quiet(); grp_stall = 1; step("R9");
    quiet(); disp_is_store = 1; sq_full = 1; grp_stall = 1; step("R8");
    quiet(); disp_is_load = 1; lq_full = 1; disp_is_store = 1; sq_full = 1; step("R8");
    drain("R9");
    quiet(); grp_stall = 1; disp_valid = 1; step("R8");
    // random phase
    begin
      void'($urandom(32'h5eed));
      for (int k = 0; k < 4000; k++) begin
        int pick;
        quiet();
        disp_valid = ($urandom % 3) != 0;
        disp_seq = SEQ_W'($urandom % 24);
        disp_users = USR_W'($urandom);
        disp_ops_ready = $urandom % 2;
        disp_is_load = ($urandom % 8) == 0;
        disp_is_store = ($urandom % 8) == 0;
        lq_full = ($urandom % 4) == 0;
        sq_full = ($urandom % 4) == 0;
        grp_stall = ($urandom % 10) == 0;
        res_avail = ($urandom % 4) != 0;
        opnd_rdy = N'($urandom);
        pick = $urandom % N;
        wb_valid = ($urandom % 3) == 0;
        wb_tag = TAG_W'(pick);
        step(k[0] ? "R4" : "R8");
      end
    end
    drain("R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule